// File: doc/BRIEF.md
# Input-Capture Period Meter

This block measures the period of an external square wave and reports it in timer ticks. A prescaler derives a timer tick from the system clock by a power-of-two factor chosen on a 3-bit select. A free-running counter of `CNT_W` bits advances on every tick.

The raw input passes through a two-flop synchronizer and an edge detector, and a 2-bit mode picks which edges count. On every selected edge the counter value is copied into a capture register and a capture flag is raised. Both flags clear only when a one is written to their bit.

A measurement starts with a start strobe. The next selected edge becomes the reference. Counter wraps are then counted until the following selected edge. The result is the wrap count shifted above the low difference, and the wrap count is corrected by one when the second sample is below the first, so a period longer than one counter turn is still reported exactly. The wrap count saturates, and a sticky error marks any result that lost wraps.

Top module: `period_meter`

## Requirements
- R1: The counter advances once every 2^N system clocks, where N is `div_sel` (0 to 7). N=0 advances it on every clock, N=1 on every second clock and N=7 on every 128th clock.
- R2: `edge_sel` selects the edges that count: 00 none, 01 rising, 10 falling, 11 both. A selected edge is acted on 3 clocks after the clock edge at which `sig_in` changed: two clocks for the synchronizer and one for the register that captures.
- R3: On every selected edge, `cap_val` takes the counter value and `cap_flag` is set. This happens whether or not a measurement is running.
- R4: The flags clear only by writing one. `flag_wr` bit 0 clears `cap_flag` and bit 1 clears `wrap_flag`. A zero bit leaves its flag as it was, and a flag that is set and cleared in the same clock stays set.
- R5: `wrap_flag` is set when the counter steps from all ones to zero.
- R6: After `start`, the first selected edge is the reference and the second ends the measurement. `period` equals the exact number of ticks between the two edges: wrap count × 2^CNT_W + (second − first) mod 2^CNT_W, with the wrap count lowered by one when the second sample is below the first.
- R7: A period of a single tick is resolved.
- R8: `done` is high for exactly one clock, together with a valid `period`. Each start yields one result. Edges after `done` leave `done` and `period` unchanged until the next start.
- R9: The wrap count saturates at its maximum. A wrap that arrives while the count is at its maximum sets `sat_err`, which stays set until the next `start`.
- R10: After reset, `period`, `done`, `sat_err`, `cap_val`, `cap_flag` and `wrap_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Asynchronous signal under measurement |
| div_sel | input | 3 | Prescale exponent N, tick = clock / 2^N |
| edge_sel | input | 2 | Edge mode: 00 none, 01 rising, 10 falling, 11 both |
| start | input | 1 | Arms one measurement |
| flag_wr | input | 2 | Write-one-to-clear: bit 0 capture flag, bit 1 wrap flag |
| period | output | CNT_W+OVF_W | Measured period in ticks |
| done | output | 1 | One-clock pulse when `period` is valid |
| sat_err | output | 1 | Sticky: the wrap count saturated |
| cap_val | output | CNT_W | Last captured counter value |
| cap_flag | output | 1 | A selected edge was captured |
| wrap_flag | output | 1 | The counter wrapped |

## Verification
The bench builds the meter with an 8-bit counter and a 4-bit wrap count. At that size a counter wrap comes every 256 ticks, so a single measurement covers many wraps and both orderings of the two samples. Saturation of the wrap count is reached within about four thousand clocks. Each edge spacing is a multiple of 2^N clocks, so the expected tick count is known whatever phase the free-running prescaler has.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ARM  = 2'b01,
        ST_MEAS = 2'b10
    } meas_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    localparam int FLAG_CAP  = 0;
    localparam int FLAG_WRAP = 1;

    function automatic logic edge_match(edge_mode_e mode, edge_ev_t ev);
        logic hit;
        case (mode)
            EDGE_RISE: hit = ev.rise;
            EDGE_FALL: hit = ev.fall;
            EDGE_ANY:  hit = ev.rise | ev.fall;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/pm_tick_gen.sv
module pm_tick_gen #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    localparam int PRE_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    // bit i of the mask takes part in the match when the exponent exceeds i
    for (genvar i = 0; i < PRE_W; i++) begin : g_mask
        assign mask[i] = (int'(div_sel) > i);
    end

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + 1'b1;
    end

    assign tick = &(pre_q | ~mask);

    p_tick_gap_r1: assert property (@(posedge clk) disable iff (rst)
        (tick && div_sel != '0) |=> (!tick || div_sel != $past(div_sel)));

endmodule

// File: rtl/pm_edge_sync.sv
module pm_edge_sync (
    input  logic       clk,
    input  logic       rst,
    input  logic       sig_in,
    input  logic [1:0] edge_sel,
    output logic       hit
);
    import pm_pkg::*;

    logic [2:0] sh_q;
    edge_ev_t   ev;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[1:0], sig_in};
    end

    always_comb begin
        ev.rise = sh_q[1] & ~sh_q[2];
        ev.fall = ~sh_q[1] & sh_q[2];
        hit     = edge_match(edge_mode_e'(edge_sel), ev);
    end

    p_off_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (edge_sel == 2'b00) |-> !hit);

endmodule

// File: rtl/pm_wrap_counter.sv
module pm_wrap_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
    end

    assign wrap = tick & (&cnt);

    p_wrap_zero_r5: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt == '0));

    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

endmodule

// File: rtl/pm_measure_ctrl.sv
module pm_measure_ctrl #(
    parameter int CNT_W = 16,
    parameter int OVF_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic                   hit,
    input  logic                   wrap,
    input  logic [CNT_W-1:0]       cnt,
    output logic [CNT_W+OVF_W-1:0] period,
    output logic                   done,
    output logic                   sat_err
);
    import pm_pkg::*;

    localparam logic [OVF_W-1:0] OVF_MAX = '1;

    meas_state_e      state;
    logic [CNT_W-1:0] first_q;
    logic [OVF_W-1:0] ovf_q;
    logic [CNT_W-1:0] diff;
    logic             below;
    logic [OVF_W-1:0] ovf_adj;

    always_comb begin
        diff    = cnt - first_q;
        below   = (cnt < first_q);
        ovf_adj = ovf_q - OVF_W'(below);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            first_q <= '0;
            ovf_q   <= '0;
            period  <= '0;
            done    <= 1'b0;
            sat_err <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                state   <= ST_ARM;
                sat_err <= 1'b0;
            end else begin
                case (state)
                    ST_ARM: if (hit) begin
                        first_q <= cnt;
                        // a wrap in this clock follows the sample, so it counts
                        ovf_q   <= wrap ? OVF_W'(1) : '0;
                        state   <= ST_MEAS;
                    end
                    ST_MEAS: if (hit) begin
                        period <= {ovf_adj, diff};
                        done   <= 1'b1;
                        state  <= ST_IDLE;
                    end else if (wrap) begin
                        if (ovf_q == OVF_MAX) sat_err <= 1'b1;
                        else                  ovf_q   <= ovf_q + 1'b1;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_from_meas_r8: assert property (@(posedge clk) disable iff (rst)
        (state != ST_MEAS) |=> !done);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (sat_err && !start) |=> sat_err);

    p_result_held_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !start) |=> $stable(period));

endmodule

// File: rtl/period_meter.sv
module period_meter #(
    parameter int CNT_W = 16,
    parameter int OVF_W = 16,
    parameter int SEL_W = 3,
    localparam int PER_W = CNT_W + OVF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sig_in,
    input  logic [SEL_W-1:0] div_sel,
    input  logic [1:0]       edge_sel,
    input  logic             start,
    input  logic [1:0]       flag_wr,
    output logic [PER_W-1:0] period,
    output logic             done,
    output logic             sat_err,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_flag,
    output logic             wrap_flag
);
    import pm_pkg::*;

    logic             tick;
    logic             hit;
    logic             wrap;
    logic [CNT_W-1:0] cnt;

    pm_tick_gen #(.SEL_W(SEL_W)) u_tick (
        .clk(clk), .rst(rst), .div_sel(div_sel), .tick(tick)
    );

    pm_edge_sync u_sync (
        .clk(clk), .rst(rst), .sig_in(sig_in), .edge_sel(edge_sel), .hit(hit)
    );

    pm_wrap_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .cnt(cnt), .wrap(wrap)
    );

    pm_measure_ctrl #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .hit(hit), .wrap(wrap),
        .cnt(cnt), .period(period), .done(done), .sat_err(sat_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_val   <= '0;
            cap_flag  <= 1'b0;
            wrap_flag <= 1'b0;
        end else begin
            if (hit) cap_val <= cnt;
            // a set event in the same clock wins over the clear
            if (hit)                    cap_flag <= 1'b1;
            else if (flag_wr[FLAG_CAP]) cap_flag <= 1'b0;
            if (wrap)                    wrap_flag <= 1'b1;
            else if (flag_wr[FLAG_WRAP]) wrap_flag <= 1'b0;
        end
    end

    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        hit |=> (cap_flag && cap_val == $past(cnt)));

    p_w1c_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (cap_flag && !flag_wr[FLAG_CAP]) |=> cap_flag);

    p_wrapflag_r5: assert property (@(posedge clk) disable iff (rst)
        wrap |=> wrap_flag);

endmodule

// File: tb/period_meter_tb.sv
module period_meter_tb;
    localparam int CW = 8;
    localparam int OW = 4;
    localparam int PW = CW + OW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sig_in = 1'b0;
    logic [2:0]    div_sel = '0;
    logic [1:0]    edge_sel = 2'b01;
    logic          start = 1'b0;
    logic [1:0]    flag_wr = '0;
    logic [PW-1:0] period;
    logic          done;
    logic          sat_err;
    logic [CW-1:0] cap_val;
    logic          cap_flag;
    logic          wrap_flag;

    period_meter #(.CNT_W(CW), .OVF_W(OW), .SEL_W(3)) u_dut (
        .clk(clk), .rst(rst), .sig_in(sig_in), .div_sel(div_sel),
        .edge_sel(edge_sel), .start(start), .flag_wr(flag_wr),
        .period(period), .done(done), .sat_err(sat_err), .cap_val(cap_val),
        .cap_flag(cap_flag), .wrap_flag(wrap_flag)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit run = 0;
    bit ended = 0;
    int q_cyc[$];
    int q_per[$];
    int q_err[$];
    int first_at = -1;
    int first_cap = 0;

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !ended) begin
            n_bad++;
            $display("FAIL watchdog: got cycle %0d expected under 150000", cyc);
            summary();
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // per-clock reference: done is expected exactly in the cycles queued
    always @(negedge clk) begin
        if (run && !ended) begin
            automatic bit exp_done = (q_cyc.size() > 0 && q_cyc[0] == cyc);
            chk("R8 done", int'(done), int'(exp_done));
            if (cyc == first_at) begin
                first_cap = int'(cap_val);
                chk("R3 cap_flag after first edge", int'(cap_flag), 1);
            end
            if (exp_done) begin
                if (q_err[0] == 0)
                    chk("R6 period", int'(period), q_per[0]);
                chk("R9 sat_err", int'(sat_err), q_err[0]);
                chk("R3 capture difference", (int'(cap_val) - first_cap) & ((1 << CW) - 1),
                    q_per[0] & ((1 << CW) - 1));
                void'(q_cyc.pop_front());
                void'(q_per.pop_front());
                void'(q_err.pop_front());
            end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_end(input int ticks, input int err);
        q_cyc.push_back(cyc + 3);
        q_per.push_back(ticks);
        q_err.push_back(err);
    endtask

    // mode: 1 rising, 2 falling, 3 both; spacings are multiples of 2^sel
    task automatic measure(input int sel, input int mode, input int hi, input int lo, input int err);
        @(negedge clk);
        div_sel  = 3'(sel);
        edge_sel = 2'(mode);
        wait_n(4);
        start = 1'b1;
        wait_n(1);
        start = 1'b0;
        wait_n(4);
        case (mode)
            1: begin
                first_at = cyc + 3; sig_in = 1'b1; wait_n(hi);
                sig_in = 1'b0; wait_n(lo);
                expect_end((hi + lo) >> sel, err); sig_in = 1'b1; wait_n(hi);
                sig_in = 1'b0;
            end
            2: begin
                sig_in = 1'b1; wait_n(hi);
                first_at = cyc + 3; sig_in = 1'b0; wait_n(lo);
                sig_in = 1'b1; wait_n(hi);
                expect_end((hi + lo) >> sel, err); sig_in = 1'b0;
            end
            default: begin
                first_at = cyc + 3; sig_in = 1'b1; wait_n(hi);
                expect_end(hi >> sel, err); sig_in = 1'b0;
            end
        endcase
        wait_n(10);
    endtask

    initial begin
        wait_n(5);
        chk("R10 period", int'(period), 0);
        chk("R10 done", int'(done), 0);
        chk("R10 sat_err", int'(sat_err), 0);
        chk("R10 cap_val", int'(cap_val), 0);
        chk("R10 cap_flag", int'(cap_flag), 0);
        chk("R10 wrap_flag", int'(wrap_flag), 0);
        rst = 1'b0;
        run = 1;
        wait_n(4);

        // R6 R1: several spacings and prescales
        measure(0, 1, 50, 50, 0);
        measure(0, 1, 300, 213, 0);
        measure(0, 1, 128, 128, 0);
        measure(0, 1, 1900, 1900, 0);
        measure(2, 1, 200, 200, 0);
        measure(7, 1, 1280, 1280, 0);
        measure(3, 1, 8, 8, 0);
        // R7: one tick
        measure(1, 1, 1, 1, 0);
        // R2: falling and both edges
        measure(0, 2, 30, 70, 0);
        measure(0, 3, 37, 200, 0);
        // R9: saturation, then cleared by the next start
        measure(0, 1, 2073, 2073, 1);
        measure(0, 1, 60, 40, 0);

        // R8: edges without a start change nothing
        begin
            automatic int held = int'(period);
            for (int i = 0; i < 4; i++) begin
                sig_in = ~sig_in;
                wait_n(5);
            end
            sig_in = 1'b0;
            wait_n(5);
            chk("R8 period held", int'(period), held);
        end

        // R4 R5: write-one-to-clear flags
        div_sel = 3'd7;
        wait_n(2);
        chk("R5 wrap_flag set", int'(wrap_flag), 1);
        chk("R3 cap_flag set", int'(cap_flag), 1);
        flag_wr = 2'b00; wait_n(1); flag_wr = 2'b00; wait_n(1);
        chk("R4 zero write keeps cap_flag", int'(cap_flag), 1);
        chk("R4 zero write keeps wrap_flag", int'(wrap_flag), 1);
        flag_wr = 2'b01; wait_n(1); flag_wr = 2'b00; wait_n(1);
        chk("R4 cap_flag cleared", int'(cap_flag), 0);
        chk("R4 wrap_flag untouched", int'(wrap_flag), 1);
        flag_wr = 2'b10; wait_n(1); flag_wr = 2'b00; wait_n(1);
        chk("R4 wrap_flag cleared", int'(wrap_flag), 0);

        // R2: mode 00 captures nothing and never finishes
        edge_sel = 2'b00;
        start = 1'b1; wait_n(1); start = 1'b0; wait_n(4);
        for (int i = 0; i < 6; i++) begin
            sig_in = ~sig_in;
            wait_n(6);
        end
        chk("R2 mode off cap_flag", int'(cap_flag), 0);

        // R5: the flag rises again after a wrap
        div_sel = 3'd0;
        wait_n(300);
        chk("R5 wrap_flag after wrap", int'(wrap_flag), 1);
        chk("R8 no pending result", q_cyc.size(), 0);

        summary();
    end
endmodule